// File: doc/BRIEF.md
# Three-Phase Gate Interlock with Dead-Time Insertion

This block sits between a motor controller's PWM outputs and three half-bridge gate drivers. For every phase it receives a high-side command that is active high and a low-side command that is active low. A shared shutdown input is active low. The block turns these into one high-gate enable and one low-gate enable per phase. The command and shutdown inputs are asynchronous to the block clock, so each passes through a register synchronizer before it is used.

Three mechanisms stop a phase from shorting the supply:
- A request for both gates of a phase is decoded as "both off".
- After either gate of a phase turns off, the opposite gate waits a programmable number of clock cycles (`DEAD_CYC`) before it may turn on. This wait applies even when the two command edges are simultaneous or close together.
- Shutdown, a low-side supply undervoltage flag and a per-phase bootstrap undervoltage flag override the commands.

The undervoltage flags are already synchronous to the clock, and their hysteresis is handled where they are generated. Each phase has its own dead-time counter and runs independently of the others. The block has no streaming data path, so every pin is a plain level control with no valid/ready handshake.

Top module: `halfbridge_guard`

## Requirements
- R1: With shutdown high and no undervoltage, a phase decodes its commands as follows: high command 1 with low command 1 drives only the high gate; high command 0 with low command 0 drives only the low gate; high command 0 with low command 1 drives neither gate. Bit i of each per-phase bus is phase i (0 = U, 1 = V, 2 = W).
- R2: While `halt_n` is 0, every gate output is 0 no later than `SYNC_STAGES`+1 clock edges after `halt_n` falls, whatever the commands are.
- R3: A phase whose high command is 1 while its low command is 0 holds both of its gates at 0.
- R4: After a gate of a phase falls, the opposite gate of that phase rises no earlier than `DEAD_CYC`+1 clock edges later. If the opposite command is already present, or arrives within the dead time, the gate rises exactly at that edge.
- R5: When the opposite command arrives after the dead time has already expired, the gate follows it directly, `SYNC_STAGES`+1 clock edges after the command changes.
- R6: During reset all gates are 0. A command present at reset release turns its gate on exactly `DEAD_CYC`+`SYNC_STAGES`+1 edges after release.
- R7: `uv_boot[i]`=1 forces `gate_hi[i]` to 0 at the next clock edge and leaves `gate_lo[i]` unaffected.
- R8: `uv_main`=1 forces every gate output to 0 at the next clock edge.
- R9: Each phase follows only its own commands and bootstrap flag.
- R10: Shutdown cancels any pending turn-on. After `halt_n` returns high, a waiting command turns its gate on exactly `DEAD_CYC`+`SYNC_STAGES`+1 edges later.
- R11: The high and low gates of one phase are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd | input | PHASES | High-side commands, active high, asynchronous |
| lo_cmd_n | input | PHASES | Low-side commands, active low, asynchronous |
| halt_n | input | 1 | Shutdown, active low, asynchronous |
| uv_main | input | 1 | Low-side supply undervoltage flag, synchronous |
| uv_boot | input | PHASES | Per-phase bootstrap undervoltage flags, synchronous |
| gate_hi | output | PHASES | High-gate enables |
| gate_lo | output | PHASES | Low-gate enables |

## Verification
The assertions check the following on every cycle: gate exclusivity, the blanking effect of shutdown, conflicting commands and both undervoltage flags, the source of every rising gate, and a minimum both-off gap of `DEAD_CYC`+1 before any turn-on.

Only the bench scenarios show the exact timing. These are the turn-on edge after reset and after shutdown release, and the precise rise edge for simultaneous, close and widely spaced command edges (the last being the direct-follow case). The bench also checks that the phases do not affect one another under mixed command patterns.

// File: rtl/gi_pkg.sv
package gi_pkg;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_HIGH  = 2'd1,
    REQ_LOW   = 2'd2,
    REQ_CLASH = 2'd3
  } req_t;

  // hi is active high, lo_n is active low
  function automatic req_t classify(input logic hi, input logic lo_n);
    unique case ({hi, lo_n})
      2'b11:   return REQ_HIGH;
      2'b00:   return REQ_LOW;
      2'b10:   return REQ_CLASH;
      default: return REQ_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gi_sync.sv
module gi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gi_decode.sv
module gi_decode
  import gi_pkg::*;
(
  input  logic hi,
  input  logic lo_n,
  input  logic halt,
  input  logic uv_main,
  input  logic uv_boot,
  output logic want_h,
  output logic want_l
);
  req_t req;
  logic blocked;

  always_comb begin
    req     = classify(hi, lo_n);
    blocked = halt | uv_main;
    want_h  = !blocked && !uv_boot && (req == REQ_HIGH);
    want_l  = !blocked && (req == REQ_LOW);
  end
endmodule

// File: rtl/gi_deadtime.sv
module gi_deadtime #(
  parameter int DEAD_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic want_h,
  input  logic want_l,
  output logic gh,
  output logic gl
);
  localparam int CW = $clog2(DEAD_CYC + 2);
  localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC);
  localparam logic [CW-1:0] GAP_MIN = CW'(DEAD_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          gh_q, gl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gh_q  <= 1'b0;
      gl_q  <= 1'b0;
      cnt_q <= RELOAD;
    end else if (halt) begin
      gh_q  <= 1'b0;
      gl_q  <= 1'b0;
      cnt_q <= RELOAD;
    end else if (gh_q && !want_h) begin
      gh_q  <= 1'b0;
      cnt_q <= RELOAD;
    end else if (gl_q && !want_l) begin
      gl_q  <= 1'b0;
      cnt_q <= RELOAD;
    end else if (!gh_q && !gl_q) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else if (want_h) gh_q <= 1'b1;
      else if (want_l) gl_q <= 1'b1;
    end
  end

  assign gh = gh_q;
  assign gl = gl_q;

  // checker: cycles both gates have been off, saturating
  logic [CW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else if (gh_q || gl_q) gap_q <= '0;
    else if (gap_q < GAP_MIN) gap_q <= gap_q + 1'b1;
  end

  a_r4_gap_before_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl_q) |-> gap_q >= GAP_MIN);
  a_r4_gap_before_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gh_q) |-> gap_q >= GAP_MIN);
  a_r11_one_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gh_q, gl_q}));
endmodule

// File: rtl/halfbridge_guard.sv
module halfbridge_guard #(
  parameter int PHASES = 3,
  parameter int DEAD_CYC = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] hi_cmd,
  input  logic [PHASES-1:0] lo_cmd_n,
  input  logic              halt_n,
  input  logic              uv_main,
  input  logic [PHASES-1:0] uv_boot,
  output logic [PHASES-1:0] gate_hi,
  output logic [PHASES-1:0] gate_lo
);
  localparam int SW = 2 * PHASES + 1;
  // safe reset image: high off, low released, shutdown active
  localparam logic [SW-1:0] SYNC_RST = {{PHASES{1'b0}}, {PHASES{1'b1}}, 1'b0};

  logic [SW-1:0]     sync_q;
  logic [PHASES-1:0] hi_s, lo_n_s;
  logic              halt_s;

  gi_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({hi_cmd, lo_cmd_n, halt_n}),
    .q     (sync_q)
  );

  assign hi_s   = sync_q[SW-1 -: PHASES];
  assign lo_n_s = sync_q[PHASES : 1];
  assign halt_s = !sync_q[0];

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    logic want_h, want_l;

    gi_decode u_dec (
      .hi      (hi_s[p]),
      .lo_n    (lo_n_s[p]),
      .halt    (halt_s),
      .uv_main (uv_main),
      .uv_boot (uv_boot[p]),
      .want_h  (want_h),
      .want_l  (want_l)
    );

    gi_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
      .clk    (clk),
      .rst_n  (rst_n),
      .halt   (halt_s),
      .want_h (want_h),
      .want_l (want_l),
      .gh     (gate_hi[p]),
      .gl     (gate_lo[p])
    );

    a_r1_high_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[p]) |-> $past(hi_s[p] && lo_n_s[p]));
    a_r1_low_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo[p]) |-> $past(!hi_s[p] && !lo_n_s[p]));
    a_r2_halt_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      halt_s |=> (!gate_hi[p] && !gate_lo[p]));
    a_r3_clash_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_s[p] && !lo_n_s[p]) |=> (!gate_hi[p] && !gate_lo[p]));
    a_r7_boot_high_off: assert property (@(posedge clk) disable iff (!rst_n)
      uv_boot[p] |=> !gate_hi[p]);
    a_r8_main_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      uv_main |=> (!gate_hi[p] && !gate_lo[p]));
  end
endmodule

// File: tb/halfbridge_guard_tb.sv
module halfbridge_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int DT = 4;
  localparam int SS = 2;
  localparam int LAT = SS + 1;
  localparam int SETTLE = DT + 12;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] hi_cmd = '0, lo_cmd_n = '1, uv_boot = '0;
  logic halt_n = 1'b1, uv_main = 1'b0;
  logic [NP-1:0] gate_hi, gate_lo;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfbridge_guard #(.PHASES(NP), .DEAD_CYC(DT), .SYNC_STAGES(SS)) u_dut (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd_n(lo_cmd_n),
    .halt_n(halt_n), .uv_main(uv_main), .uv_boot(uv_boot),
    .gate_hi(gate_hi), .gate_lo(gate_lo));

  // {hi, lo_n, halt_n, uv_main, uv_boot, expected gate_hi, expected gate_lo}
  localparam logic [16:0] VEC [NVEC] = '{
    {3'b000, 3'b111, 1'b1, 1'b0, 3'b000, 3'b000, 3'b000},
    {3'b111, 3'b111, 1'b1, 1'b0, 3'b000, 3'b111, 3'b000},
    {3'b000, 3'b000, 1'b1, 1'b0, 3'b000, 3'b000, 3'b111},
    {3'b111, 3'b000, 1'b1, 1'b0, 3'b000, 3'b000, 3'b000},
    {3'b101, 3'b011, 1'b1, 1'b0, 3'b000, 3'b001, 3'b000},
    {3'b010, 3'b100, 1'b1, 1'b0, 3'b000, 3'b000, 3'b001},
    {3'b110, 3'b110, 1'b1, 1'b0, 3'b000, 3'b110, 3'b001},
    {3'b111, 3'b111, 1'b0, 1'b0, 3'b000, 3'b000, 3'b000},
    {3'b000, 3'b000, 1'b1, 1'b1, 3'b000, 3'b000, 3'b000},
    {3'b111, 3'b111, 1'b1, 1'b0, 3'b010, 3'b101, 3'b000},
    {3'b000, 3'b000, 1'b1, 1'b0, 3'b111, 3'b000, 3'b111},
    {3'b011, 3'b011, 1'b1, 1'b0, 3'b000, 3'b011, 3'b100}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // phase U: release the on-gate command at i=0, assert the new one at i=dly
  task automatic measure(input bit to_hi, input int dly, input string req);
    int fall_c = -1, rise_c = -1;
    if (to_hi) lo_cmd_n[0] = 1'b1; else hi_cmd[0] = 1'b0;
    if (dly == 0) begin
      if (to_hi) hi_cmd[0] = 1'b1; else lo_cmd_n[0] = 1'b0;
    end
    for (int i = 1; i <= 40; i++) begin
      step(1);
      if (i == dly) begin
        if (to_hi) hi_cmd[0] = 1'b1; else lo_cmd_n[0] = 1'b0;
      end
      if (fall_c < 0 && !(to_hi ? gate_lo[0] : gate_hi[0])) fall_c = i;
      if (rise_c < 0 && (to_hi ? gate_hi[0] : gate_lo[0])) rise_c = i;
    end
    check(fall_c == LAT, req, fall_c, LAT);
    begin
      int exp_rise = (LAT + 1 + DT > dly + LAT) ? LAT + 1 + DT : dly + LAT;
      check(rise_c == exp_rise, req, rise_c, exp_rise);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R6: reset state, then first turn-on timing
    hi_cmd = '0; lo_cmd_n = '0;
    step(4);
    check(gate_hi == '0 && gate_lo == '0, "R6 reset off", {gate_hi, gate_lo}, 0);
    rst_n = 1'b1;
    for (int i = 1; i <= DT + LAT; i++) begin
      step(1);
      if (i == DT + LAT - 1)
        check(gate_lo == '0, "R6 early turn-on", gate_lo, 0);
    end
    check(gate_lo == 3'b111, "R6 first turn-on", gate_lo, 7);

    // R1 R3 R7 R8 R9 table walk
    for (int r = 0; r < NVEC; r++) begin
      {hi_cmd, lo_cmd_n, halt_n, uv_main, uv_boot} = VEC[r][16:6];
      step(SETTLE);
      check(gate_hi == VEC[r][5:3], $sformatf("R1/R3/R9 row %0d high", r), gate_hi, VEC[r][5:3]);
      check(gate_lo == VEC[r][2:0], $sformatf("R1/R3/R9 row %0d low", r), gate_lo, VEC[r][2:0]);
    end

    // R4: simultaneous edges, both directions; then close edges
    hi_cmd = '1; lo_cmd_n = '1; halt_n = 1'b1; uv_main = 1'b0; uv_boot = '0;
    step(SETTLE);
    measure(1'b0, 0, "R4 high-to-low simultaneous");
    measure(1'b1, 0, "R4 low-to-high simultaneous");
    measure(1'b0, 2, "R4 close edges");
    // R5: separation beyond the dead time follows directly
    step(SETTLE);
    measure(1'b1, DT + 6, "R5 direct follow");

    // R2: shutdown latency from low state
    hi_cmd = '0; lo_cmd_n = '0;
    step(SETTLE);
    halt_n = 1'b0;
    step(LAT - 1);
    check(gate_lo == 3'b111, "R2 before shutdown lands", gate_lo, 7);
    step(1);
    check(gate_lo == '0 && gate_hi == '0, "R2 shutdown off", gate_lo, 0);
    step(6);
    check(gate_lo == '0, "R2 shutdown holds", gate_lo, 0);
    // R10: release restarts the dead time
    halt_n = 1'b1;
    step(DT + LAT - 1);
    check(gate_lo == '0, "R10 no early turn-on", gate_lo, 0);
    step(1);
    check(gate_lo == 3'b111, "R10 turn-on after release", gate_lo, 7);

    // R7: boot flag leaves low gates running, drops high gate in one edge
    uv_boot = 3'b111;
    step(3);
    check(gate_lo == 3'b111, "R7 low unaffected", gate_lo, 7);
    uv_boot = '0; hi_cmd = '1; lo_cmd_n = '1;
    step(SETTLE);
    uv_boot = 3'b001;
    step(1);
    check(gate_hi == 3'b110, "R7 high off next edge", gate_hi, 6);
    uv_boot = '0;
    step(SETTLE);
    check(gate_hi == 3'b111, "R7 high recovers", gate_hi, 7);

    // R8: supply flag drops everything at the next edge
    hi_cmd = 3'b011; lo_cmd_n = 3'b011;
    step(SETTLE);
    uv_main = 1'b1;
    step(1);
    check(gate_hi == '0 && gate_lo == '0, "R8 all off", {gate_hi, gate_lo}, 0);
    uv_main = 1'b0;

    step(5);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule